// File: doc/BRIEF.md
# ATA Task-File Register Emulator

This block stands in for the device side of a disk task-file register set. It sits behind a simple byte-addressed register window. Device registers sit at even offsets, two bytes apart, from 0xD0 upward. A host that expects a real drive can probe registers, soft-reset the device and run an identify command. The host writes the geometry/address registers and reads them back. It pulses the reset bit in the device-control register and reads back a fixed signature. It can also issue the identify command and pull one sector of configuration words through the data port.

The host bus is a single request channel with a one-beat response. A request (`bus_req`) is accepted in every cycle it is high: the block never applies back-pressure and has no ready signal. A read request is answered exactly one cycle later with `bus_rvalid` high and `bus_rdata` holding the value. The host may issue one request per cycle back to back. A read of the data port is itself the hand-off of one word: the emulator advances to the next word on each accepted data read while data is pending. The configuration words are computed internally. They leave the block with their two bytes swapped, because the device byte order differs from the host's.

Top module: `ata_taskfile_emu`

## Requirements
- R1: Offsets 0xD2 (feature), 0xD4 (sector count), 0xD6 (sector number), 0xD8 (cylinder low), 0xDA (cylinder high) and 0xDC (drive/head, low nibble = top LBA bits) each read back exactly the last 8-bit value written, in `bus_rdata[7:0]` with `bus_rdata[15:8]` zero.
- R2: Every read request is answered in the next cycle with `bus_rvalid` high; `bus_rvalid` is low in any cycle that follows no read request.
- R3: Status at 0xDE encodes bit 0 error, bit 3 data pending, bit 7 busy; after power-on reset it reads 0x00, and sector count and sector number read 1.
- R4: Offset 0xEC reads back the last value written to it (device control), e.g. 0x0E then 0x0A.
- R5: While device-control bit 2 (soft reset) is set, status reads 0x80. When a write clears that bit, sector count and sector number load 1, both cylinder registers load 0, and status reads 0x00.
- R6: A command write to 0xDE while soft reset is held is ignored: after release, status is 0x00 and data reads return 0.
- R7: Writing command 0xEC to 0xDE starts an identify transfer; status then reads 0x08.
- R8: During the transfer, the n-th data read at 0xD0 (n from 0) returns the device word {n[7:0]^0xC3, n[7:0]} with bytes swapped, i.e. {n[7:0], n[7:0]^0xC3}.
- R9: After the 256th data word, status returns to 0x00 and further data reads return 0.
- R10: A data read while no data is pending returns 0 and does not advance the word position (the next transfer still begins at word 0).
- R11: Any command other than 0xEC sets status to 0x01; a following 0xEC command clears it to 0x08.
- R12: Reads of unmapped offsets return 0 and writes to them change no register.
- R13: Setting soft reset during a transfer aborts it: after release, status is 0x00 and data reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, always accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 16 | Read response data |

## Verification
The hardest state to reach from the ports is the interplay of an interrupted transfer with the word counter. A transfer must be left partly drained, soft reset must be raised and released, and the bench must show that no stale word leaks out. To get there, the bench starts an identify, reads a few words, and toggles device-control bit 2. It then probes the status and data ports. It also reads the data port while idle before a full transfer, to show that the first delivered word is still word 0. Around these, the bench sweeps all 256 values through every read/write register and all 256 command codes.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam logic [7:0] OFS_DATA  = 8'hD0;
  localparam logic [7:0] OFS_FEAT  = 8'hD2;
  localparam logic [7:0] OFS_SCNT  = 8'hD4;
  localparam logic [7:0] OFS_SNUM  = 8'hD6;
  localparam logic [7:0] OFS_CYLL  = 8'hD8;
  localparam logic [7:0] OFS_CYLH  = 8'hDA;
  localparam logic [7:0] OFS_DRVH  = 8'hDC;
  localparam logic [7:0] OFS_STCMD = 8'hDE;
  localparam logic [7:0] OFS_ALTDC = 8'hEC;

  localparam logic [7:0] CMD_IDENT = 8'hEC;
  localparam int         SRST_BIT  = 2;

  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;

  typedef enum logic [1:0] {XS_IDLE, XS_DRQ, XS_ERR} xs_t;
endpackage

// File: rtl/tfe_cfgrom.sv
module tfe_cfgrom #(
  parameter int          WORDS = 256,
  parameter logic [7:0]  KEY   = 8'hC3,
  parameter bit          SWAP  = 1'b1,
  localparam int         IW    = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx,
  output logic [15:0]   bus_word
);
  logic [7:0]  lo_b;
  logic [15:0] dev_word;

  assign lo_b     = 8'(idx);
  assign dev_word = {lo_b ^ KEY, lo_b};

  generate
    if (SWAP) begin : g_swap
      assign bus_word = {dev_word[7:0], dev_word[15:8]};
    end else begin : g_flat
      assign bus_word = dev_word;
    end
  endgenerate
endmodule

// File: rtl/tfe_xfer.sv
module tfe_xfer
  import tfe_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic          data_rd,
  output logic          drq,
  output logic          err,
  output logic [IW-1:0] word_idx
);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  xs_t state;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      state    <= XS_IDLE;
      word_idx <= '0;
    end else if (cmd_we) begin
      word_idx <= '0;
      state    <= (cmd_code == CMD_IDENT) ? XS_DRQ : XS_ERR;
    end else if (data_rd && state == XS_DRQ) begin
      if (word_idx == LAST) begin
        state    <= XS_IDLE;
        word_idx <= '0;
      end else begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

  assign drq = (state == XS_DRQ);
  assign err = (state == XS_ERR);

  // R9
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && data_rd && !cmd_we && !srst && word_idx == LAST) |=> !drq);

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_rd && !cmd_we && !srst) |=> $stable(word_idx));
endmodule

// File: rtl/ata_taskfile_emu.sv
module ata_taskfile_emu
  import tfe_pkg::*;
#(
  parameter int         WORDS = 256,
  parameter logic [7:0] KEY   = 8'hC3,
  localparam int        IW    = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        bus_rvalid,
  output logic [15:0] bus_rdata
);
  logic [7:0] feat_q, scnt_q, snum_q, cyll_q, cylh_q, drvh_q, devctl_q;
  logic       wr, rd, srst, sig_load, cmd_we, data_rd;
  logic       drq, err;
  logic [IW-1:0] word_idx;
  logic [15:0]   rom_word;
  logic [7:0]    status;
  logic [15:0]   rd_mux;

  assign wr       = bus_req &&  bus_we;
  assign rd       = bus_req && !bus_we;
  assign srst     = devctl_q[SRST_BIT];
  assign sig_load = wr && bus_addr == OFS_ALTDC && srst && !bus_wdata[SRST_BIT];
  assign cmd_we   = wr && bus_addr == OFS_STCMD && !srst;
  assign data_rd  = rd && bus_addr == OFS_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n || sig_load) begin
      scnt_q <= 8'h01;
      snum_q <= 8'h01;
      cyll_q <= 8'h00;
      cylh_q <= 8'h00;
    end else if (wr) begin
      case (bus_addr)
        OFS_SCNT: scnt_q <= bus_wdata;
        OFS_SNUM: snum_q <= bus_wdata;
        OFS_CYLL: cyll_q <= bus_wdata;
        OFS_CYLH: cylh_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q   <= 8'h00;
      drvh_q   <= 8'h00;
      devctl_q <= 8'h00;
    end else if (wr) begin
      case (bus_addr)
        OFS_FEAT:  feat_q   <= bus_wdata;
        OFS_DRVH:  drvh_q   <= bus_wdata;
        OFS_ALTDC: devctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  tfe_xfer #(.WORDS(WORDS)) u_xfer (
    .clk(clk), .rst_n(rst_n), .srst(srst), .cmd_we(cmd_we),
    .cmd_code(bus_wdata), .data_rd(data_rd),
    .drq(drq), .err(err), .word_idx(word_idx)
  );

  tfe_cfgrom #(.WORDS(WORDS), .KEY(KEY), .SWAP(1'b1)) u_rom (
    .idx(word_idx), .bus_word(rom_word)
  );

  always_comb begin
    if (srst)      status = ST_BUSY;
    else if (drq)  status = ST_DRQ;
    else if (err)  status = ST_ERR;
    else           status = 8'h00;
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA:  rd_mux = drq ? rom_word : 16'h0000;
      OFS_FEAT:  rd_mux = {8'h00, feat_q};
      OFS_SCNT:  rd_mux = {8'h00, scnt_q};
      OFS_SNUM:  rd_mux = {8'h00, snum_q};
      OFS_CYLL:  rd_mux = {8'h00, cyll_q};
      OFS_CYLH:  rd_mux = {8'h00, cylh_q};
      OFS_DRVH:  rd_mux = {8'h00, drvh_q};
      OFS_STCMD: rd_mux = {8'h00, status};
      OFS_ALTDC: rd_mux = {8'h00, devctl_q};
      default:   rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 16'h0000;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : 16'h0000;
    end
  end

  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  // R5
  sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devctl_q[SRST_BIT]) |-> (scnt_q == 8'h01 && snum_q == 8'h01 &&
                                   cyll_q == 8'h00 && cylh_q == 8'h00));

  // R6
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_STCMD && srst) |=> (!drq && !err));

  // R10
  zero_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !drq) |=> bus_rdata == 16'h0000);
endmodule

// File: tb/sim_ata_taskfile_emu.sv
`timescale 1ns/1ps
module sim_ata_taskfile_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rvalid;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ata_taskfile_emu u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    v = bus_rdata;
    if (bus_rvalid !== 1'b1) begin
      total++; bad++;
      $display("FAIL R2 actual=%b expected=1", bus_rvalid);
    end
  endtask

  function automatic logic [15:0] exp_word(input int n);
    logic [7:0] b = 8'(n);
    return {b, b ^ 8'hC3};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle cycle has no response
    chk("R2", {15'd0, bus_rvalid}, 16'd0);
    // R3: reset state
    rd(8'hDE, v); chk("R3", v, 16'h0000);
    rd(8'hD4, v); chk("R3", v, 16'h0001);
    rd(8'hD6, v); chk("R3", v, 16'h0001);

    // R1: sweep all values through every read/write register
    for (int i = 0; i < 256; i++) begin
      wr(8'hD2, 8'(i));
      wr(8'hD4, 8'(i) ^ 8'h55);
      wr(8'hD6, ~8'(i));
      wr(8'hD8, 8'(i + 1));
      wr(8'hDA, 8'(i) ^ 8'hAA);
      wr(8'hDC, 8'(i + 7));
      rd(8'hD2, v); chk("R1", v, {8'h00, 8'(i)});
      rd(8'hD4, v); chk("R1", v, {8'h00, 8'(i) ^ 8'h55});
      rd(8'hD6, v); chk("R1", v, {8'h00, ~8'(i)});
      rd(8'hD8, v); chk("R1", v, {8'h00, 8'(i + 1)});
      rd(8'hDA, v); chk("R1", v, {8'h00, 8'(i) ^ 8'hAA});
      rd(8'hDC, v); chk("R1", v, {8'h00, 8'(i + 7)});
    end
    wr(8'hDC, 8'hA0);
    rd(8'hDC, v); chk("R1", v, 16'h00A0);

    // R12: unmapped offsets
    wr(8'hF0, 8'h5A);
    wr(8'hE0, 8'h77);
    rd(8'hF0, v); chk("R12", v, 16'h0000);
    rd(8'hE0, v); chk("R12", v, 16'h0000);
    rd(8'hD4, v); chk("R12", v, {8'h00, 8'hFF ^ 8'h55});
    rd(8'hDC, v); chk("R12", v, 16'h00A0);

    // R4/R5/R6: soft reset with an ignored command
    wr(8'hEC, 8'h0E);
    rd(8'hEC, v); chk("R4", v, 16'h000E);
    rd(8'hDE, v); chk("R5", v, 16'h0080);
    wr(8'hDE, 8'hEC);
    rd(8'hDE, v); chk("R6", v, 16'h0080);
    wr(8'hEC, 8'h0A);
    rd(8'hEC, v); chk("R4", v, 16'h000A);
    rd(8'hD4, v); chk("R5", v, 16'h0001);
    rd(8'hD6, v); chk("R5", v, 16'h0001);
    rd(8'hD8, v); chk("R5", v, 16'h0000);
    rd(8'hDA, v); chk("R5", v, 16'h0000);
    rd(8'hDE, v); chk("R6", v, 16'h0000);
    rd(8'hD0, v); chk("R6", v, 16'h0000);

    // R10: idle data reads do not advance
    rd(8'hD0, v); chk("R10", v, 16'h0000);
    rd(8'hD0, v); chk("R10", v, 16'h0000);
    // R7/R8/R9: full identify
    wr(8'hDE, 8'hEC);
    rd(8'hDE, v); chk("R7", v, 16'h0008);
    rd(8'hEC, v); chk("R4", v, 16'h000A);
    for (int n = 0; n < 256; n++) begin
      rd(8'hD0, v); chk("R8", v, exp_word(n));
    end
    rd(8'hDE, v); chk("R9", v, 16'h0000);
    rd(8'hD0, v); chk("R9", v, 16'h0000);

    // R11: every other command code errors
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hEC) begin
        wr(8'hDE, 8'(c));
        rd(8'hDE, v); chk("R11", v, 16'h0001);
      end
    end
    wr(8'hDE, 8'hEC);
    rd(8'hDE, v); chk("R11", v, 16'h0008);

    // R13: abort mid-transfer
    for (int n = 0; n < 5; n++) begin
      rd(8'hD0, v); chk("R13", v, exp_word(n));
    end
    wr(8'hEC, 8'h0E);
    rd(8'hDE, v); chk("R13", v, 16'h0080);
    wr(8'hEC, 8'h0A);
    rd(8'hDE, v); chk("R13", v, 16'h0000);
    rd(8'hD0, v); chk("R13", v, 16'h0000);
    wr(8'hDE, 8'hEC);
    rd(8'hD0, v); chk("R13", v, exp_word(0));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule